// File: doc/BRIEF.md
# Parallel LCD Bus Cycle Generator

This block drives the strobe-based parallel bus of an external display controller, one access at a time. A requester presents a command write, a data write or a read start on a single-cycle request port. The block takes a snapshot of the request and the configuration, then plays out one bus cycle. The cycle is measured in ticks, and a tick lasts one or two clocks of the interface.

Two 32-bit timing words set where the chip-select, write-strobe and read-strobe edges fall inside the cycle. They also set how long a write or a read cycle lasts and on which tick read data is latched. The register-select line separates command accesses from data accesses. The bus carries 8 or 16 bits per access. The block reports `busy` while a cycle runs and pulses `done` for one clock when it ends. The captured read value is then available on `rd_data`.

Top module: `lcd_bus_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `lcd_d_oe` are 0, and `lcd_cs_n`, `lcd_we_n`, `lcd_re_n` and `lcd_rs` are 1.
- R2: When `cfg_div2` is 0 a tick is one clock. When it is 1 a tick is two clocks.
- R3: Tick t of a cycle counts from 0, and tick 0 begins with the first clock after the request is accepted. During tick t, `lcd_cs_n` is low exactly when cs_on <= t < cs_off. The fields are cs_on = tim0[3:0] and cs_off = tim0[9:4]. In a write cycle `lcd_we_n` is low exactly when we_on <= t < we_off, with we_on = tim0[13:10] and we_off = tim0[19:14]. In a read cycle `lcd_re_n` is low exactly when re_on <= t < re_off, with re_on = tim0[23:20] and re_off = tim0[29:24]. With valid settings (cs_on no later than the other on times, and cs_off at least we_off and re_off), no strobe is low while `lcd_cs_n` is high.
- R4: A write cycle lasts we_cycle = tim1[5:0] ticks and a read cycle lasts re_cycle = tim1[11:6] ticks, with a value of 0 treated as 1. `busy` is high for the whole cycle. `done` is high for the single clock that follows the last tick.
- R5: `req_kind` 0 is a command write and drives `lcd_rs` low. Kind 1 is a data write and kind 2 is a read; both drive `lcd_rs` high. `lcd_rs` stays stable from tick 0 to the end of the cycle.
- R6: `cfg_width` equal to 3 selects the 16-bit bus. Any other value selects the 8-bit bus. In 8-bit mode a write drives `req_wdata[7:0]` with the upper lines at 0, and a read returns `lcd_d_in[7:0]` zero-extended.
- R7: A read latches `lcd_d_in` on the clock edge that ends the first clock of tick access_time, where access_time = tim1[27:22]. If access_time is not below re_cycle, the latch happens on the last tick instead. `rd_data` holds the value until the next read.
- R8: A request that arrives while `busy` is high is ignored. It does not start a cycle and does not change the running one.
- R9: `lcd_re_n` stays high in write cycles and `lcd_we_n` stays high in read cycles. `lcd_d_oe` is high exactly while a write cycle runs, and `lcd_d_out` holds the write value for that whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_div2 | input | 1 | Tick length: 0 = one clock, 1 = two clocks |
| cfg_width | input | 2 | Bus width: 3 = 16 bits, other values = 8 bits |
| cfg_tim0 | input | 32 | Edge timing word (strobe on and off ticks) |
| cfg_tim1 | input | 32 | Cycle timing word (cycle lengths, access time) |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_kind | input | 2 | 0 command write, 1 data write, 2 read |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | A bus cycle is running |
| done | output | 1 | One-clock pulse at the end of a cycle |
| rd_data | output | 16 | Last captured read value |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_we_n | output | 1 | Write strobe, active low |
| lcd_re_n | output | 1 | Read strobe, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_d_out | output | 16 | Bus data driven on writes |
| lcd_d_oe | output | 1 | Bus output enable |
| lcd_d_in | input | 16 | Bus data sampled on reads |

## Verification
The bench drives `lcd_d_in` with a value that changes every clock. A read that latches one clock early or late therefore returns a wrong number, and this exposes an off-by-one in the access-time or divide-by-two logic.

The bench compares every strobe on every clock of every cycle against the half-open windows. This catches a window that closes one tick late or a strobe that opens in the wrong cycle type. A case with access_time past the cycle end checks the clamp, where a design without it would never capture. The cycle-end clock is checked for both tick lengths, and here a counter that ends one tick short or long shows up at once.

A request held high during a running cycle would show as an extra `done` or as changed bus data if the design accepted it. A one-tick minimum cycle checks that the first and last tick can coincide.

// File: rtl/lcdbus_pkg.sv
package lcdbus_pkg;
  localparam int ON_W  = 4;   // width of an assert-time field
  localparam int OFF_W = 6;   // width of deassert, cycle and access fields
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_DATA  = 2'd1,
    K_READ  = 2'd2,
    K_SPARE = 2'd3
  } kind_e;

  typedef struct packed {
    logic [ON_W-1:0]  cs_on;
    logic [OFF_W-1:0] cs_off;
    logic [ON_W-1:0]  we_on;
    logic [OFF_W-1:0] we_off;
    logic [ON_W-1:0]  re_on;
    logic [OFF_W-1:0] re_off;
    logic [OFF_W-1:0] we_cyc;
    logic [OFF_W-1:0] re_cyc;
    logic [OFF_W-1:0] actim;
  } tim_t;
endpackage

// File: rtl/lcdbus_tick_gen.sv
module lcdbus_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic div2,
  output logic tick_first,
  output logic tick_last
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) phase_q <= 1'b0;
    else if (div2)              phase_q <= ~phase_q;
    else                        phase_q <= 1'b0;
  end

  assign tick_first = !div2 || !phase_q;
  assign tick_last  = !div2 ||  phase_q;
endmodule

// File: rtl/lcdbus_strobe.sv
module lcdbus_strobe #(
  parameter int ON_BITS  = 4,
  parameter int OFF_BITS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                clear,
  input  logic                gate,
  input  logic [OFF_BITS-1:0] t_nxt,
  input  logic [ON_BITS-1:0]  on_t,
  input  logic [OFF_BITS-1:0] off_t,
  output logic                strobe_n
);
  logic in_window;

  assign in_window = (t_nxt >= OFF_BITS'(on_t)) && (t_nxt < off_t);

  always_ff @(posedge clk) begin
    if (rst || clear) strobe_n <= 1'b1;
    else if (load)    strobe_n <= !(gate && in_window);
  end
endmodule

// File: rtl/lcdbus_capture.sv
module lcdbus_capture #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          wide,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] rd_data
);
  localparam int PAD = DW - NW;

  always_ff @(posedge clk) begin
    if (rst)       rd_data <= '0;
    else if (fire) rd_data <= wide ? d_in : {{PAD{1'b0}}, d_in[NW-1:0]};
  end
endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_div2,
  input  logic [1:0]    cfg_width,
  input  logic [31:0]   cfg_tim0,
  input  logic [31:0]   cfg_tim1,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          lcd_cs_n,
  output logic          lcd_we_n,
  output logic          lcd_re_n,
  output logic          lcd_rs,
  output logic [DW-1:0] lcd_d_out,
  output logic          lcd_d_oe,
  input  logic [DW-1:0] lcd_d_in
);
  import lcdbus_pkg::*;

  localparam int CW    = OFF_W;
  localparam int NSTB  = 3;
  localparam int PAD   = DW - NW;

  tim_t  tim_in, tim_q, tim_nxt;
  kind_e kind_q, kind_nxt, req_k;
  logic  busy_q, done_q, w16_q, div2_q, rs_q, doe_q;
  logic [DW-1:0] dout_q;
  logic [CW-1:0] t_q, t_nxt, cyc_raw, cyc_eff, cap_tick;
  logic accept, end_cyc, advance, tick_first, tick_last, cap_fire;
  logic tim_unused;

  // Field extraction from the two timing words
  always_comb begin
    tim_in.cs_on  = cfg_tim0[3:0];
    tim_in.cs_off = cfg_tim0[9:4];
    tim_in.we_on  = cfg_tim0[13:10];
    tim_in.we_off = cfg_tim0[19:14];
    tim_in.re_on  = cfg_tim0[23:20];
    tim_in.re_off = cfg_tim0[29:24];
    tim_in.we_cyc = cfg_tim1[5:0];
    tim_in.re_cyc = cfg_tim1[11:6];
    tim_in.actim  = cfg_tim1[27:22];
  end
  assign tim_unused = ^{cfg_tim0[31:30], cfg_tim1[21:12], cfg_tim1[31:28]};

  assign req_k    = kind_e'(req_kind);
  assign accept   = req_valid && !busy_q;
  assign tim_nxt  = accept ? tim_in : tim_q;
  assign kind_nxt = accept ? req_k  : kind_q;

  assign cyc_raw  = (kind_q == K_READ) ? tim_q.re_cyc : tim_q.we_cyc;
  assign cyc_eff  = (cyc_raw == '0) ? CW'(1) : cyc_raw;
  assign cap_tick = (tim_q.actim >= cyc_eff) ? cyc_eff - CW'(1) : tim_q.actim;

  assign end_cyc  = busy_q && tick_last && (t_q == cyc_eff - CW'(1));
  assign advance  = busy_q && tick_last && !end_cyc;
  assign t_nxt    = accept ? '0 : t_q + CW'(1);
  assign cap_fire = busy_q && tick_first && (t_q == cap_tick) && (kind_q == K_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      t_q    <= '0;
      tim_q  <= '0;
      kind_q <= K_CMD;
      w16_q  <= 1'b0;
      div2_q <= 1'b0;
      rs_q   <= 1'b1;
      doe_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      done_q <= end_cyc;
      tim_q  <= tim_nxt;
      kind_q <= kind_nxt;
      if (accept) begin
        busy_q <= 1'b1;
        t_q    <= '0;
        w16_q  <= (cfg_width == 2'd3);
        div2_q <= cfg_div2;
        rs_q   <= (req_k != K_CMD);
        doe_q  <= (req_k != K_READ);
        dout_q <= (cfg_width == 2'd3) ? req_wdata
                                      : {{PAD{1'b0}}, req_wdata[NW-1:0]};
      end else if (end_cyc) begin
        busy_q <= 1'b0;
        doe_q  <= 1'b0;
      end else if (advance) begin
        t_q <= t_nxt;
      end
    end
  end

  lcdbus_tick_gen u_tick (
    .clk        (clk),
    .rst        (rst),
    .restart    (accept),
    .run        (busy_q),
    .div2       (div2_q),
    .tick_first (tick_first),
    .tick_last  (tick_last)
  );

  // Strobe 0 = chip select, 1 = write, 2 = read
  logic [ON_W-1:0]  s_on   [NSTB];
  logic [OFF_W-1:0] s_off  [NSTB];
  logic [NSTB-1:0]  s_gate;
  logic [NSTB-1:0]  s_n;

  assign s_on[0]  = tim_nxt.cs_on;
  assign s_off[0] = tim_nxt.cs_off;
  assign s_on[1]  = tim_nxt.we_on;
  assign s_off[1] = tim_nxt.we_off;
  assign s_on[2]  = tim_nxt.re_on;
  assign s_off[2] = tim_nxt.re_off;
  assign s_gate   = {kind_nxt == K_READ, kind_nxt != K_READ, 1'b1};

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    lcdbus_strobe #(.ON_BITS(ON_W), .OFF_BITS(OFF_W)) u_stb (
      .clk      (clk),
      .rst      (rst),
      .load     (accept || advance),
      .clear    (end_cyc),
      .gate     (s_gate[g]),
      .t_nxt    (t_nxt),
      .on_t     (s_on[g]),
      .off_t    (s_off[g]),
      .strobe_n (s_n[g])
    );
  end

  lcdbus_capture #(.DW(DW), .NW(NW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .fire    (cap_fire),
    .wide    (w16_q),
    .d_in    (lcd_d_in),
    .rd_data (rd_data)
  );

  assign busy      = busy_q;
  assign done      = done_q;
  assign lcd_cs_n  = s_n[0];
  assign lcd_we_n  = s_n[1];
  assign lcd_re_n  = s_n[2];
  assign lcd_rs    = rs_q;
  assign lcd_d_out = dout_q;
  assign lcd_d_oe  = doe_q;
endmodule

// File: rtl/lcd_bus_engine_chk.sv
module lcd_bus_engine_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic we_n,
  input logic re_n,
  input logic rs,
  input logic d_oe
);
  // R1: reset leaves the bus idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && cs_n && we_n && re_n && !d_oe));

  // R4: done lasts one clock and follows a running cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) && !busy));

  // R5: register select holds through a cycle
  a_r5_rs_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(rs));

  // R9: never both strobes at once, nothing driven when idle
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!d_oe && we_n && re_n && cs_n));

  // R3: with valid settings strobes sit inside chip select
  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !re_n) |-> !cs_n);
endmodule

bind lcd_bus_engine lcd_bus_engine_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .busy (busy),
  .done (done),
  .cs_n (lcd_cs_n),
  .we_n (lcd_we_n),
  .re_n (lcd_re_n),
  .rs   (lcd_rs),
  .d_oe (lcd_d_oe)
);

// File: tb/sim_lcd_bus_engine.sv
`timescale 1ns/1ps
module sim_lcd_bus_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_div2 = 1'b0;
  logic [1:0]  cfg_width = 2'd3;
  logic [31:0] cfg_tim0 = '0;
  logic [31:0] cfg_tim1 = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, lcd_cs_n, lcd_we_n, lcd_re_n, lcd_rs, lcd_d_oe;
  logic [15:0] rd_data, lcd_d_out, lcd_d_in;

  int cyc_cnt = 0;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;
  assign lcd_d_in = 16'(cyc_cnt);

  lcd_bus_engine u0 (
    .clk(clk), .rst(rst), .cfg_div2(cfg_div2), .cfg_width(cfg_width),
    .cfg_tim0(cfg_tim0), .cfg_tim1(cfg_tim1), .req_valid(req_valid),
    .req_kind(req_kind), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .lcd_cs_n(lcd_cs_n), .lcd_we_n(lcd_we_n),
    .lcd_re_n(lcd_re_n), .lcd_rs(lcd_rs), .lcd_d_out(lcd_d_out),
    .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
  );

  typedef struct {
    int kind; int wdata; int k; int dd; int cyc; int cap; bit w16;
    int cs_on; int cs_off; int we_on; int we_off; int re_on; int re_off;
  } item_t;
  item_t q[$];

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_req(input int kind, input int wdata,
                        input int cson, input int csoff, input int weon, input int weoff,
                        input int reon, input int reoff, input int wecyc, input int recyc,
                        input int actim, input bit d2, input bit w16);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    cfg_tim0  = 32'(cson) | (32'(csoff) << 4) | (32'(weon) << 10) | (32'(weoff) << 14)
              | (32'(reon) << 20) | (32'(reoff) << 24);
    cfg_tim1  = 32'(wecyc) | (32'(recyc) << 6) | (32'h15 << 12) | (32'(actim) << 22);
    cfg_div2  = d2;
    cfg_width = w16 ? 2'd3 : 2'd0;
    req_kind  = 2'(kind);
    req_wdata = 16'(wdata);
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    it.kind = kind; it.wdata = wdata; it.k = cyc_cnt; it.dd = d2 ? 2 : 1;
    it.w16 = w16; it.cyc = (kind == 2) ? recyc : wecyc;
    it.cap = (actim >= it.cyc) ? it.cyc - 1 : actim;
    it.cs_on = cson; it.cs_off = csoff; it.we_on = weon; it.we_off = weoff;
    it.re_on = reon; it.re_off = reoff;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares the bus against the queued expectation every clock
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (busy) begin
        if (q.size() == 0) chk("R8 cycle without request", 1, 0);
        else begin
          item_t it;
          int t;
          bit wr;
          it = q[0];
          t  = (cyc_cnt - it.k) / it.dd;
          wr = (it.kind != 2);
          chk("R3 cs_n window", lcd_cs_n, !(t >= it.cs_on && t < it.cs_off));
          chk("R3 R9 we_n window", lcd_we_n, !(wr && t >= it.we_on && t < it.we_off));
          chk("R3 R9 re_n window", lcd_re_n, !(!wr && t >= it.re_on && t < it.re_off));
          chk("R5 rs level", lcd_rs, (it.kind == 0) ? 0 : 1);
          chk("R9 d_oe", lcd_d_oe, wr);
          if (wr)
            chk("R6 R8 write data", lcd_d_out,
                it.w16 ? (it.wdata & 16'hffff) : (it.wdata & 16'hff));
        end
      end
      if (done) begin
        if (q.size() == 0) chk("R8 done without request", 1, 0);
        else begin
          item_t it;
          int v;
          it = q.pop_front();
          chk("R2 R4 cycle end clock", cyc_cnt, it.k + it.cyc * it.dd);
          chk("R4 busy low with done", busy, 0);
          if (it.kind == 2) begin
            v = it.k + it.cap * it.dd;
            chk("R6 R7 read capture", rd_data, it.w16 ? (v & 16'hffff) : (v & 16'hff));
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL R4 watchdog: got hung expected idle");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 strobes", {lcd_cs_n, lcd_we_n, lcd_re_n, lcd_rs}, 4'hf);
    chk("R1 d_oe", lcd_d_oe, 0);

    // R5 command write, 16-bit, one clock per tick
    do_req(0, 16'h1234, 1, 8, 2, 6, 1, 3, 9, 4, 2, 0, 1);
    // R6 data write, 8-bit, R2 two clocks per tick
    do_req(1, 16'hA5C3, 0, 5, 1, 4, 0, 1, 6, 2, 1, 1, 0);
    // R7 reads: 16-bit div1, 8-bit div2
    do_req(2, 0, 1, 7, 1, 2, 2, 6, 3, 8, 4, 0, 1);
    do_req(2, 0, 0, 6, 0, 1, 1, 5, 1, 7, 3, 1, 0);
    // R7 access time past cycle end clamps to last tick
    do_req(2, 0, 0, 4, 0, 1, 1, 4, 1, 5, 20, 1, 1);
    // R4 one-tick minimum cycle
    do_req(1, 16'hBEEF, 0, 1, 0, 1, 0, 1, 1, 1, 1, 0, 1);

    // R8 request held during a long running cycle
    do_req(0, 16'h0F0F, 1, 20, 2, 18, 1, 3, 24, 4, 2, 1, 1);
    repeat (4) @(negedge clk);
    req_kind  = 2'd2;
    req_wdata = 16'h5555;
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;

    // back-to-back writes, alternating width and tick length
    for (int i = 0; i < 6; i++)
      do_req(i % 2, 16'h3C00 + i * 16'h0111, 0, 4 + i, 1, 3 + i, 0, 1, 4 + i, 2,
             1, i[0], i[1]);

    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R8 no extra cycle", busy, 0);
    chk("R4 queue drained", q.size(), 0);
    chk("R9 idle bus", {lcd_cs_n, lcd_we_n, lcd_re_n, lcd_d_oe}, 4'he);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule